// File: doc/BRIEF.md
# Full-Cycle Serial Bus Host Engine

This block is the host side of a four-wire serial link (SCK, chip select, MOSI, MISO). Its timing gives each side a whole SCK period to capture a bit, which lets the link run near its top rated SCK rate of about 66 MHz. The peripheral on the far end updates MISO after each falling SCK edge and captures MOSI on each rising edge. This engine does the reverse. It updates MOSI on a rising edge, so the peripheral takes that bit one rising edge later. It samples MISO on the falling edge that comes one period after the peripheral drove it. The bit stream in each direction therefore trails the other side's edges by one period, and a transfer of N bytes needs 8N+1 rising edges.

The host gives a byte, a continue flag and a start pulse while `busy` is low. SCK is made inside the system clock domain: each SCK level lasts a programmable number of system clocks, so the division ratio is always even and at least two. A mode input selects the idle level of SCK, low or high. When the continue flag is set, chip select stays low once the byte is shifted out. SCK then waits low and `busy` drops until the next byte arrives. Each reply byte is presented with a one-cycle valid pulse. Bytes travel most significant bit first in both directions.

Top module: `fc_spi_master`

## Requirements
- R1: After reset `cs_n` is 1, and `sck`, `mosi`, `busy` and `rx_valid` are all 0.
- R2: While chip select is low and the engine is not paused, every SCK level lasts exactly `cfg_half` system clocks. This includes the first level, measured from the fall of chip select. One SCK period is therefore 2*`cfg_half` clocks.
- R3: `mosi` changes only in the system clock in which `sck` rises. Bit j of the outgoing stream (bytes in order, MSB first) is driven at the (j+1)-th rising edge after chip select falls. A peripheral that samples at rising edge j+2 therefore receives every byte intact.
- R4: MISO bit j of the incoming stream is sampled at the falling edge that follows rising edge j+2. This is one full period after a peripheral drives it at the falling edge that follows rising edge j+1. Bytes are assembled MSB first.
- R5: `rx_valid` is high for one system clock and carries the assembled byte on `rx_byte`. It rises in the cycle in which `sck` falls for the eighth capture of that byte.
- R6: With `cfg_mode3`=0 the SCK idle level is low; with `cfg_mode3`=1 it is high. In mode 3 the falling edge before the first rising edge samples nothing. After the transfer, SCK returns to the selected idle level.
- R7: When a byte is started with `cont`=1, chip select stays low after its eighth bit is driven. SCK is then held low and `busy` is low until the next `start`.
- R8: Chip select rises no earlier than 2*`cfg_half` clocks after the last SCK edge, and `sck` does not change in the cycle in which `cs_n` rises.
- R9: A `start` pulse while `busy` is high has no effect.
- R10: A transfer of N bytes has exactly 8N+1 rising SCK edges. It has 8N+1 falling edges in mode 0 and 8N+2 in mode 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | HALF_W | System clocks per SCK level (0 treated as 1) |
| cfg_mode3 | input | 1 | SCK idle level: 0 low, 1 high |
| start | input | 1 | Accept `tx_byte` when `busy` is low |
| cont | input | 1 | Keep chip select low after this byte |
| tx_byte | input | 8 | Byte to send, MSB first |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| busy | output | 1 | High while a byte is in flight or chip select is closing |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Host-to-peripheral data |
| miso | input | 1 | Peripheral-to-host data |

## Verification
The embedded properties check, on every cycle, the relations between edges. MOSI moves only with a rising SCK edge. The valid strobe comes with a falling edge and lasts one cycle. SCK is low whenever the engine is paused with chip select low. SCK stays still when chip select rises, and two edge strobes never come back to back. Other behaviour needs the bench's scenarios and its responder, which drives on falling edges and samples on rising edges. These scenarios show that the one-period offsets deliver whole bytes intact in both directions. They also cover the exact edge counts, the per-level timing for several divider values, the mode-3 leading edge, pauses between continued bytes, and that a start while busy is ignored.

// File: rtl/fc_spi_pkg.sv
package fc_spi_pkg;
    localparam int BYTE_W = 8;
    localparam int BITS_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_TAIL,
        ST_CSUP
    } fc_state_e;

    typedef struct packed {
        fc_state_e          st;
        logic               sck;
        logic               cs_n;
        logic               mode3;
        logic               cont;
        logic [BITS_W-1:0]  bits;
        logic [1:0]         rises;
        logic               fin;
        logic               tail;
    } fc_ctl_t;
endpackage

// File: rtl/fc_edge_tick.sv
module fc_edge_tick #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_q, cnt_d, lim;

    always_comb begin
        lim   = (half == '0) ? '0 : half - HALF_W'(1);
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + HALF_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a level longer than one clock never sees two strobes in a row
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0) |=> !tick);
endmodule

// File: rtl/fc_shift_pair.sv
module fc_shift_pair
    import fc_spi_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  logic         launch,
    input  logic         capture,
    input  logic         clr,
    input  logic         miso_in,
    output logic         mosi_out,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  tx_sh;
        logic [W-1:0]  rx_sh;
        logic [CW-1:0] rx_cnt;
        logic          mosi;
        logic [W-1:0]  rx_byte;
        logic          rx_valid;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        if (load) d.tx_sh = load_byte;
        if (launch) begin
            d.mosi  = q.tx_sh[W-1];
            d.tx_sh = {q.tx_sh[W-2:0], 1'b0};
        end
        if (clr) d.rx_cnt = '0;
        if (capture) begin
            d.rx_sh  = {q.rx_sh[W-2:0], miso_in};
            d.rx_cnt = q.rx_cnt + CW'(1);
            if (q.rx_cnt == CW'(W - 1)) begin
                d.rx_cnt   = '0;
                d.rx_byte  = {q.rx_sh[W-2:0], miso_in};
                d.rx_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mosi_out = q.mosi;
    assign rx_byte  = q.rx_byte;
    assign rx_valid = q.rx_valid;

    // R5: the byte strobe never lasts two cycles
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/fc_spi_master.sv
module fc_spi_master
    import fc_spi_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              cfg_mode3,
    input  logic              start,
    input  logic              cont,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(BYTE_W);

    fc_ctl_t q, d;
    logic run, tick, load, launch, capture, clr;

    fc_edge_tick #(.HALF_W(HALF_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .half (cfg_half),
        .tick (tick)
    );

    fc_shift_pair #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_byte(tx_byte),
        .launch   (launch),
        .capture  (capture),
        .clr      (clr),
        .miso_in  (miso),
        .mosi_out (mosi),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    assign run  = (q.st == ST_RUN) || (q.st == ST_TAIL);
    assign busy = !((q.st == ST_IDLE) || (q.st == ST_PAUSE));
    assign sck  = q.sck;
    assign cs_n = q.cs_n;

    always_comb begin
        d       = q;
        load    = 1'b0;
        launch  = 1'b0;
        capture = 1'b0;
        clr     = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.sck  = cfg_mode3;
                d.cs_n = 1'b1;
                if (start) begin
                    d.cs_n  = 1'b0;
                    d.mode3 = cfg_mode3;
                    d.cont  = cont;
                    d.bits  = '0;
                    d.rises = 2'd0;
                    d.fin   = 1'b0;
                    load    = 1'b1;
                    clr     = 1'b1;
                    d.st    = ST_RUN;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (q.sck) begin
                        d.sck = 1'b0;
                        if (q.rises == 2'd2) capture = 1'b1;
                        if (q.fin) begin
                            d.tail = 1'b0;
                            d.st   = ST_TAIL;
                        end
                    end else if (q.bits == LAST_BIT && q.cont) begin
                        d.st = ST_PAUSE;
                    end else begin
                        d.sck   = 1'b1;
                        d.rises = (q.rises == 2'd2) ? 2'd2 : q.rises + 2'd1;
                        if (q.bits < LAST_BIT) begin
                            launch = 1'b1;
                            d.bits = q.bits + BITS_W'(1);
                        end else begin
                            d.fin = 1'b1;
                        end
                    end
                end
            end
            ST_PAUSE: begin
                if (start) begin
                    load   = 1'b1;
                    d.cont = cont;
                    d.bits = '0;
                    d.st   = ST_RUN;
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (q.tail) begin
                        d.cs_n = 1'b1;
                        d.st   = ST_CSUP;
                    end else begin
                        d.tail = 1'b1;
                    end
                end
            end
            ST_CSUP: begin
                d.sck = q.mode3;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R3: the data line moves only together with a rising serial clock
    a_r3_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $rose(sck));

    // R5: a received byte is announced with a falling serial clock
    a_r5_valid_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $fell(sck));

    // R7: a paused, still-selected link holds its clock low
    a_r7_pause_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n) |-> !sck);

    // R8: deselect never coincides with a clock edge
    a_r8_cs_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $stable(sck));
endmodule

// File: tb/fc_spi_master_bench.sv
`timescale 1ns/1ps
module fc_spi_master_bench;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] cfg_half = 8'd1;
    logic          cfg_mode3 = 1'b0;
    logic          start = 1'b0;
    logic          cont = 1'b0;
    logic [7:0]    tx_byte = 8'h00;
    logic [7:0]    rx_byte;
    logic          rx_valid, busy, sck, cs_n, mosi;
    logic          miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] resp_tx [16];
    logic [7:0] r_got [16];
    logic [7:0] m_got [16];
    int r_n = 0, m_n = 0, rc = 0, fc = 0, viol = 0, r_bits = 0;
    int gap = 0, gmin = 1000000, gmax = 0, tailgap = 0;
    logic [7:0] r_sh = 8'h00;
    logic sck_p = 1'b0, mosi_p = 1'b0, cs_p = 1'b1;

    always #2 clk = ~clk;

    fc_spi_master #(.HALF_W(HW)) u_fc_spi_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_half (cfg_half),
        .cfg_mode3(cfg_mode3),
        .start    (start),
        .cont     (cont),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .busy     (busy),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .miso     (miso)
    );

    // Responder and monitor: peripheral drives after falls, samples on rises
    initial begin
        for (int i = 0; i < 16; i++) resp_tx[i] = 8'h00;
        forever begin
            @(negedge clk);
            if (cs_p && !cs_n) gap = 0;
            else if (!cs_n) gap++;
            if (!cs_n) begin
                if (sck !== sck_p) begin
                    if (gap < gmin) gmin = gap;
                    if (gap > gmax) gmax = gap;
                    gap = 0;
                end
                if (sck && !sck_p) begin
                    rc++;
                    if (rc >= 2) begin
                        r_sh = {r_sh[6:0], mosi_p};
                        r_bits++;
                        if (r_bits == 8) begin
                            r_got[r_n % 16] = r_sh;
                            r_n++;
                            r_bits = 0;
                        end
                    end
                end
                if (!sck && sck_p) begin
                    fc++;
                    if (rc >= 1) miso = resp_tx[((rc - 1) / 8) % 16][7 - ((rc - 1) % 8)];
                end
            end
            if (!cs_p && cs_n) tailgap = gap + 1;
            if (mosi !== mosi_p && !(sck && !sck_p)) viol++;
            if (rx_valid) begin
                m_got[m_n % 16] = rx_byte;
                m_n++;
            end
            sck_p  = sck;
            mosi_p = mosi;
            cs_p   = cs_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic clear_mon();
        r_n = 0; m_n = 0; rc = 0; fc = 0; viol = 0; r_bits = 0;
        gmin = 1000000; gmax = 0; tailgap = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic c);
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        tx_byte = b;
        cont    = c;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        cont    = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !(cs_n && !busy); i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic setup(input logic m, input int h);
        cfg_mode3 = m;
        cfg_half  = HW'(h);
        repeat (3) @(negedge clk);
        clear_mon();
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sck == 1'b0, "R1 sck", int'(sck), 0);
        chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    endtask

    task automatic t_single(input logic m, input int h, input logic [7:0] tb, input logic [7:0] rb);
        setup(m, h);
        resp_tx[0] = rb;
        send_byte(tb, 1'b0);
        wait_done();
        chk(r_n == 1, "R3 peripheral byte count", r_n, 1);
        chk(r_got[0] == tb, "R3 peripheral byte", int'(r_got[0]), int'(tb));
        chk(viol == 0, "R3 mosi moved off a rising edge", viol, 0);
        chk(m_n == 1, "R5 valid strobes", m_n, 1);
        chk(m_got[0] == rb, "R4 host byte", int'(m_got[0]), int'(rb));
        chk(gmin == h && gmax == h, "R2 level length", gmax, h);
        chk(tailgap >= 2 * h, "R8 deselect delay", tailgap, 2 * h);
        chk(rc == 9, "R10 rising edges", rc, 9);
        chk(fc == 9 + int'(m), "R10 falling edges", fc, 9 + int'(m));
        chk(sck == m, "R6 idle level", int'(sck), int'(m));
    endtask

    task automatic t_multi(input logic m, input int h);
        logic [7:0] tb [3];
        tb[0] = 8'h12; tb[1] = 8'h34; tb[2] = 8'hF0;
        setup(m, h);
        resp_tx[0] = 8'h9A; resp_tx[1] = 8'hBC; resp_tx[2] = 8'h0F;
        for (int k = 0; k < 3; k++) begin
            send_byte(tb[k], k < 2);
            if (k < 2) begin
                for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
                repeat (4) @(negedge clk);
                chk(cs_n == 1'b0 && sck == 1'b0 && busy == 1'b0, "R7 paused link state",
                    int'({cs_n, sck, busy}), 0);
            end
        end
        wait_done();
        chk(r_n == 3, "R7 peripheral byte count", r_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk(r_got[k] == tb[k], "R3 streamed peripheral byte", int'(r_got[k]), int'(tb[k]));
            chk(m_got[k] == resp_tx[k], "R4 streamed host byte", int'(m_got[k]), int'(resp_tx[k]));
        end
        chk(m_n == 3, "R5 valid strobes in stream", m_n, 3);
        chk(rc == 25, "R10 rising edges for three bytes", rc, 25);
        chk(viol == 0, "R3 mosi moved off a rising edge", viol, 0);
        chk(sck == m, "R6 idle level after stream", int'(sck), int'(m));
    endtask

    task automatic t_busy_ignore();
        setup(1'b0, 2);
        resp_tx[0] = 8'h66;
        send_byte(8'hA0, 1'b0);
        repeat (3) @(negedge clk);
        tx_byte = 8'h0F;
        cont    = 1'b1;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        cont    = 1'b0;
        wait_done();
        chk(r_n == 1, "R9 peripheral byte count", r_n, 1);
        chk(r_got[0] == 8'hA0, "R9 peripheral byte", int'(r_got[0]), 'hA0);
        chk(rc == 9, "R9 rising edges", rc, 9);
        chk(m_n == 1 && m_got[0] == 8'h66, "R9 host byte", int'(m_got[0]), 'h66);
        chk(cs_n == 1'b1 && busy == 1'b0, "R9 link closed", int'({cs_n, busy}), 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1..R10 run hung): actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(1'b0, 1, 8'hA5, 8'h3C);
        t_single(1'b0, 3, 8'h81, 8'h7E);
        t_single(1'b1, 2, 8'hC3, 8'h5A);
        t_single(1'b1, 1, 8'hFF, 8'h00);
        t_single(1'b0, 4, 8'h00, 8'hFF);
        t_multi(1'b0, 1);
        t_multi(1'b1, 3);
        t_busy_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule